// File: doc/BRIEF.md
# Branch Resolution and Interrupt Entry/Return Sequencer

This block sits beside the program counter of a 16-bit core. When a conditional branch resolves, it reads the zero and less-than status flags, judges the branch by its 2-bit kind, and produces a taken flag, a PC load strobe and the target address. The target is the current PC plus the displacement.

At each instruction boundary it also handles interrupts. A request pulse is latched as pending and is accepted only at a boundary while the interrupt-enable bit is set. On acceptance the block redirects the PC to a fixed vector, writes the return address into an external interrupt-return-address register, and asks for interrupt-enable to be cleared. A return-from-interrupt at a boundary reloads the PC from that register and asks for interrupt-enable to be set again.

Every output is registered. Results appear one clock after the cycle in which the inputs were presented. Saving general registers is left to software.

Top module: `brirq_seq`

## Requirements
- R1: With `br_kind` = 00 (equal), the branch is taken exactly when `flag_z` is 1.
- R2: With `br_kind` = 01 (not equal), the branch is taken exactly when `flag_z` is 0.
- R3: With `br_kind` = 10 (less), the branch is taken exactly when `flag_lt` is 1.
- R4: With `br_kind` = 11 (greater), the branch is taken exactly when `flag_lt` and `flag_z` are both 0.
- R5: One cycle after `br_en` is sampled high with the condition met, `br_taken` and `pc_load` are 1 and `pc_next` equals `pc_cur + br_disp` modulo 2^16. If the condition is not met, or `br_en` is 0, both flags are 0.
- R6: An interrupt is accepted only in a cycle with `insn_done`=1, `ien`=1 and no `reti`. One cycle later `pc_load`=1, `pc_next` equals the vector parameter (default 0x0004), `ira_we`=1, `ira_wdata` is the return address, and `ien_clr`=1.
- R7: A request pulse on `irq_req` that meets `ien`=0 or no boundary stays pending. It is accepted at the first later boundary with `ien`=1, even if `irq_req` is low by then.
- R8: `reti` with `insn_done` gives, one cycle later, `pc_load`=1, `pc_next`=`ira_val` and `ien_set`=1, with `ira_we`=0. It has priority over both branch and interrupt redirection.
- R9: If `reti` and a request meet at the same boundary, only the return happens. The request is accepted at the next boundary that has `ien`=1.
- R10: If a taken branch and an interrupt entry happen in the same cycle, `pc_next` is the vector, `ira_wdata` is the branch target, and `br_taken` is 1.
- R11: During reset every output is 0 and any pending request is discarded.
- R12: Accepting an interrupt clears its pending state. A later boundary with `ien`=1 and no new request causes no entry.
- R13: `ien_set` and `ien_clr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_en | input | 1 | A conditional branch resolves this cycle |
| br_kind | input | 2 | Branch kind: 00 eq, 01 ne, 10 lt, 11 gt |
| flag_z | input | 1 | Zero status flag |
| flag_lt | input | 1 | Less-than status flag |
| br_disp | input | 16 | Branch displacement |
| pc_cur | input | 16 | Current PC, used as the return address at a boundary |
| insn_done | input | 1 | Instruction boundary strobe |
| irq_req | input | 1 | External interrupt request pulse |
| ien | input | 1 | Interrupt-enable status bit |
| reti | input | 1 | Return-from-interrupt strobe |
| ira_val | input | 16 | Current content of the interrupt-return-address register |
| br_taken | output | 1 | Branch condition was met |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | 16 | New PC value |
| ira_we | output | 1 | Write strobe for the interrupt-return-address register |
| ira_wdata | output | 16 | Value to write into that register |
| ien_set | output | 1 | Request to set interrupt-enable |
| ien_clr | output | 1 | Request to clear interrupt-enable |

## Verification
Every output passes through a single register stage, so all results are due at the clock edge that samples the stimulus. The bench drives inputs on the falling edge, waits for the next rising edge, and samples 2 ns after it. It clears the inputs on the following falling edge, so each result is tied to exactly one stimulus cycle.

Pending-request behaviour spans several such steps. Those checks look at `pc_load` and `ira_we` at each boundary in turn. Each check covers only the boundary whose registered result is then visible.

// File: rtl/brirq_pkg.sv
package brirq_pkg;

    typedef enum logic [1:0] {
        BK_EQ = 2'b00,
        BK_NE = 2'b01,
        BK_LT = 2'b10,
        BK_GT = 2'b11
    } br_kind_e;

    localparam int unsigned KIND_W = 2;

endpackage

// File: rtl/brirq_cond.sv
module brirq_cond
    import brirq_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              flag_z,
    input  logic              flag_lt,
    output logic              met
);

    br_kind_e kind_e;

    always_comb begin
        kind_e = br_kind_e'(kind);
        unique case (kind_e)
            BK_EQ:   met = flag_z;
            BK_NE:   met = !flag_z;
            BK_LT:   met = flag_lt;
            BK_GT:   met = !flag_lt && !flag_z;
            default: met = 1'b0;
        endcase
    end

endmodule

// File: rtl/brirq_pend.sv
module brirq_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic take,
    output logic pending
);

    logic pend_d;
    logic pend_q;

    always_comb begin
        pend_d = (pend_q || irq_req) && !take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q || irq_req;

    // R7: a pending request survives until it is taken
    assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !take) |=> pend_q);

    // R7: a new request that is not taken at once becomes pending
    assert_pend_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !take) |=> pend_q);

    // R12: accepting the interrupt clears its pending state
    assert_pend_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !irq_req) |=> !pend_q);

endmodule

// File: rtl/brirq_seq.sv
module brirq_seq
    import brirq_pkg::*;
#(
    parameter int unsigned     AW  = 16,
    parameter logic [AW-1:0]   VEC = 16'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_en,
    input  logic [KIND_W-1:0] br_kind,
    input  logic              flag_z,
    input  logic              flag_lt,
    input  logic [AW-1:0]     br_disp,
    input  logic [AW-1:0]     pc_cur,
    input  logic              insn_done,
    input  logic              irq_req,
    input  logic              ien,
    input  logic              reti,
    input  logic [AW-1:0]     ira_val,
    output logic              br_taken,
    output logic              pc_load,
    output logic [AW-1:0]     pc_next,
    output logic              ira_we,
    output logic [AW-1:0]     ira_wdata,
    output logic              ien_set,
    output logic              ien_clr
);

    typedef struct packed {
        logic          br_taken;
        logic          pc_load;
        logic [AW-1:0] pc_next;
        logic          ira_we;
        logic [AW-1:0] ira_wdata;
        logic          ien_set;
        logic          ien_clr;
    } seq_out_t;

    seq_out_t out_d;
    seq_out_t out_q;

    logic          cond_met;
    logic          pending;
    logic          br_hit;
    logic          reti_go;
    logic          irq_go;
    logic [AW-1:0] br_tgt;

    brirq_cond u_cond (
        .kind    (br_kind),
        .flag_z  (flag_z),
        .flag_lt (flag_lt),
        .met     (cond_met)
    );

    brirq_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .take    (irq_go),
        .pending (pending)
    );

    always_comb begin
        br_tgt  = pc_cur + br_disp;
        br_hit  = br_en && cond_met;
        reti_go = insn_done && reti;
        irq_go  = insn_done && ien && pending && !reti;

        out_d          = '0;
        out_d.br_taken = br_hit;
        if (reti_go) begin
            out_d.pc_load = 1'b1;
            out_d.pc_next = ira_val;
            out_d.ien_set = 1'b1;
        end else if (irq_go) begin
            out_d.pc_load   = 1'b1;
            out_d.pc_next   = VEC;
            out_d.ira_we    = 1'b1;
            out_d.ira_wdata = br_hit ? br_tgt : pc_cur;
            out_d.ien_clr   = 1'b1;
        end else if (br_hit) begin
            out_d.pc_load = 1'b1;
            out_d.pc_next = br_tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign br_taken  = out_q.br_taken;
    assign pc_load   = out_q.pc_load;
    assign pc_next   = out_q.pc_next;
    assign ira_we    = out_q.ira_we;
    assign ira_wdata = out_q.ira_wdata;
    assign ien_set   = out_q.ien_set;
    assign ien_clr   = out_q.ien_clr;

    assert_ien_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(ien_set && ien_clr));

    assert_entry_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ira_we |-> (ien_clr && pc_load && pc_next == VEC));

    assert_entry_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && ien && !reti && irq_req) |=> ira_we);

    assert_no_entry_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_done || !ien || reti) |=> !ira_we);

    assert_reti_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && reti) |=> (pc_load && ien_set && !ira_we && pc_next == $past(ira_val)));

    assert_taken_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> pc_load);

    assert_no_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |=> !br_taken);

endmodule

// File: tb/sim_brirq_seq.sv
module sim_brirq_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        br_en;
    logic [1:0]  br_kind;
    logic        flag_z;
    logic        flag_lt;
    logic [15:0] br_disp;
    logic [15:0] pc_cur;
    logic        insn_done;
    logic        irq_req;
    logic        ien;
    logic        reti;
    logic [15:0] ira_val;
    logic        br_taken;
    logic        pc_load;
    logic [15:0] pc_next;
    logic        ira_we;
    logic [15:0] ira_wdata;
    logic        ien_set;
    logic        ien_clr;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    brirq_seq u0 (
        .clk(clk), .rst_n(rst_n), .br_en(br_en), .br_kind(br_kind),
        .flag_z(flag_z), .flag_lt(flag_lt), .br_disp(br_disp), .pc_cur(pc_cur),
        .insn_done(insn_done), .irq_req(irq_req), .ien(ien), .reti(reti),
        .ira_val(ira_val), .br_taken(br_taken), .pc_load(pc_load),
        .pc_next(pc_next), .ira_we(ira_we), .ira_wdata(ira_wdata),
        .ien_set(ien_set), .ien_clr(ien_clr)
    );

    // {kind[1:0], z, lt, expected_taken}
    localparam logic [4:0] TAB [16] = '{
        5'b00000, 5'b00010, 5'b00101, 5'b00111,
        5'b01001, 5'b01011, 5'b01100, 5'b01110,
        5'b10000, 5'b10011, 5'b10100, 5'b10111,
        5'b11001, 5'b11010, 5'b11100, 5'b11110
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clr();
        br_en = 0; br_kind = 0; flag_z = 0; flag_lt = 0; br_disp = 0;
        pc_cur = 0; insn_done = 0; irq_req = 0; ien = 0; reti = 0; ira_val = 0;
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clr();
        rst_n = 0;
        irq_req = 1;
        repeat (3) settle();
        check("R11", "pc_load", pc_load, 0);
        check("R11", "ira_we", ira_we, 0);
        check("R11", "outs", {br_taken, ien_set, ien_clr, pc_next, ira_wdata}, 0);
        @(negedge clk); clr(); rst_n = 1;
        // R11: the request seen during reset must not survive it
        @(negedge clk); clr(); insn_done = 1; ien = 1; settle();
        check("R11", "no entry after reset", ira_we, 0);

        for (int i = 0; i < 16; i++) begin
            @(negedge clk); clr();
            br_en = 1; br_kind = TAB[i][4:3]; flag_z = TAB[i][2]; flag_lt = TAB[i][1];
            pc_cur = 16'h1000 + 16'(i * 16); br_disp = 16'(i * 3 + 1);
            settle();
            case (TAB[i][4:3])
                2'b00:   check("R1", "br_taken eq", br_taken, TAB[i][0]);
                2'b01:   check("R2", "br_taken ne", br_taken, TAB[i][0]);
                2'b10:   check("R3", "br_taken lt", br_taken, TAB[i][0]);
                default: check("R4", "br_taken gt", br_taken, TAB[i][0]);
            endcase
            check("R5", "pc_load", pc_load, TAB[i][0]);
            if (TAB[i][0])
                check("R5", "pc_next", pc_next, 16'h1000 + 16'(i * 16) + 16'(i * 3 + 1));
        end

        // R5: no branch without br_en
        @(negedge clk); clr(); br_kind = 2'b00; flag_z = 1; settle();
        check("R5", "br_en low taken", br_taken, 0);
        check("R5", "br_en low load", pc_load, 0);

        // R5: target wraps modulo 2^16
        @(negedge clk); clr(); br_en = 1; br_kind = 2'b01;
        pc_cur = 16'hFFF0; br_disp = 16'h0020; settle();
        check("R5", "wrap pc_next", pc_next, 16'h0010);

        // R7: request with ien low, then boundary-free cycles
        @(negedge clk); clr(); irq_req = 1; insn_done = 1; ien = 0; settle();
        check("R7", "no entry ien=0", ira_we, 0);
        @(negedge clk); clr(); ien = 1; settle();
        check("R7", "no entry off boundary", pc_load, 0);
        @(negedge clk); clr(); insn_done = 1; ien = 1; pc_cur = 16'h0345; settle();
        check("R7", "pending entry ira_we", ira_we, 1);
        check("R6", "vector", pc_next, 16'h0004);
        check("R6", "ira_wdata", ira_wdata, 16'h0345);
        check("R6", "ien_clr", ien_clr, 1);

        // R12: pending cleared after entry
        @(negedge clk); clr(); insn_done = 1; ien = 1; settle();
        check("R12", "no second entry", pc_load, 0);

        // R8: return
        @(negedge clk); clr(); insn_done = 1; reti = 1; ira_val = 16'h2222; settle();
        check("R8", "pc_next", pc_next, 16'h2222);
        check("R8", "ien_set/ira_we", {ien_set, ira_we, pc_load}, 3'b101);
        check("R13", "set and clr", ien_set & ien_clr, 0);

        // R9: return and request together
        @(negedge clk); clr(); insn_done = 1; reti = 1; ien = 1; irq_req = 1;
        ira_val = 16'h0777; settle();
        check("R9", "return wins", {pc_next, ira_we, ien_set}, {16'h0777, 1'b0, 1'b1});
        @(negedge clk); clr(); insn_done = 1; ien = 1; pc_cur = 16'h0778; settle();
        check("R9", "entry next boundary", {ira_we, pc_next, ira_wdata},
              {1'b1, 16'h0004, 16'h0778});

        // R10: taken branch and interrupt together
        @(negedge clk); clr(); br_en = 1; br_kind = 2'b10; flag_lt = 1;
        pc_cur = 16'h0100; br_disp = 16'h0050; insn_done = 1; ien = 1; irq_req = 1; settle();
        check("R10", "vector", pc_next, 16'h0004);
        check("R10", "ira_wdata target", ira_wdata, 16'h0150);
        check("R10", "br_taken", br_taken, 1);

        @(negedge clk); clr(); settle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule